// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block is a clocked front end for an asynchronous static RAM of 64K bytes. A client issues one request at a time (a read or a write of a single byte at a 16-bit address) through a request/ready handshake. The controller turns each request into a pin sequence on the memory side. That side has a 16-bit address, a low-active chip select, a high-active chip select, a low-active write strobe and a low-active output enable. A bidirectional 8-bit data bus is split into a drive value, a drive enable and a receive path.

Every memory-side output comes from a flop, so none can glitch. The length of each strobe is set by the parameter `WAIT_CLKS`, the number of system clocks the strobe stays low. This lets one design serve memories of different speed grades. Between accesses the memory is deselected and held in its low-power standby. After a read, the bus is released for one clock before the controller can drive it again.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset and whenever `ready` is high, the memory is in standby: `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1 and `dq_oe`=0. `ready` is 1 after reset.
- R2: An accepted write runs as follows, counting clocks from the accept edge. There is one setup clock with the chip selected, `sram_we_n`=1 and `dq_oe`=1. Then `WAIT_CLKS` clocks follow with `sram_we_n`=0. Then one hold clock has `sram_we_n`=1 while the chip is still selected and the data is still driven. `ready` stays low for `WAIT_CLKS`+2 clocks.
- R3: An accepted read holds `sram_oe_n`=0 with the chip selected and `dq_oe`=0 for `WAIT_CLKS` clocks. `dq_in` is sampled on the last of these clocks. `rdata_valid` goes high for exactly one clock, `WAIT_CLKS` clocks after the accept edge, with `rdata` holding the sampled byte.
- R4: `sram_addr` and `dq_out` stay unchanged from the setup clock of a write until after `sram_we_n` has risen.
- R5: After a read strobe, the controller spends one clock in standby with `ready` low. A read therefore keeps `ready` low for `WAIT_CLKS`+1 clocks.
- R6: `dq_oe` is never 1 while `sram_oe_n` is 0, nor in the clock that follows a clock with `sram_oe_n`=0.
- R7: `sram_we_n` and `sram_oe_n` are never both 0.
- R8: A request presented while `ready` is low is ignored and leaves the memory contents untouched.
- R9: A byte written to any address, including 16'h0000 and 16'hFFFF, is returned by a later read of that address.
- R10: A low `rst_n` sampled at a clock edge returns the controller to the R1 standby state, even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, taken when ready is high |
| req_write | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | 16 | Word address of the access |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | 8 | Byte returned by the last read |
| rdata_valid | output | 1 | One-clock pulse marking new rdata |
| sram_addr | output | 16 | Memory address pins |
| sram_ce1_n | output | 1 | Low-active chip select |
| sram_ce2 | output | 1 | High-active chip select |
| sram_we_n | output | 1 | Low-active write strobe |
| sram_oe_n | output | 1 | Low-active output enable |
| dq_out | output | 8 | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Value received from the data bus |

## Verification
The properties make only two assumptions about the inputs: `rst_n` is low for the first clocks, and `WAIT_CLKS` is at least one. They assume nothing about when `req` arrives, so intruding requests during a busy period are legal stimulus. The bench's memory model is sound only if the address of an access stays fixed while a strobe is low. Its sampling of `dq_in` is sound only if read data settles within the strobe. The bench model meets both by updating its output byte away from the clock edge, and the stimulus draws addresses from a fixed pool that includes both ends of the address range. A reset during an access is applied only in the setup clock, before the write strobe falls, so the model never sees a strobe edge that races the deselect.

// File: rtl/sram_port_pkg.sv
// Shared types for the asynchronous SRAM port controller.
// Assumes: single-word accesses, one in flight at a time.
package sram_port_pkg;

    // Sequencer states; only IDLE accepts a new request.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RD_STROBE,
        ST_RD_RECOVER
    } seq_state_e;

    // Pin intent for one clock, decoded from a sequencer state.
    typedef struct packed {
        logic chip_sel;
        logic wr_strobe;
        logic rd_strobe;
        logic bus_drive;
    } pin_intent_t;

    // Map a state to the pin levels the memory must see during it.
    function automatic pin_intent_t intent_of(seq_state_e st);
        pin_intent_t p;
        p.chip_sel  = (st != ST_IDLE) && (st != ST_RD_RECOVER);
        p.wr_strobe = (st == ST_WR_STROBE);
        p.rd_strobe = (st == ST_RD_STROBE);
        p.bus_drive = (st == ST_WR_SETUP) || (st == ST_WR_STROBE) || (st == ST_WR_HOLD);
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Access sequencer: accepts a request in IDLE and steps through the write
// (setup, strobe, hold) or read (strobe, recover) phases. Strobe length is
// WAIT_CLKS clocks. Assumes WAIT_CLKS >= 1. Exposes the next state so that
// the pin stage can register pin levels without a decode after the flop.
module sram_seq_fsm
    import sram_port_pkg::*;
#(
    parameter int WAIT_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_write,
    output logic       ready,
    output logic       accept,
    output logic       rd_sample,
    output seq_state_e state_nxt
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       strobe_done;

    assign ready  = (state_q == ST_IDLE);
    assign accept = req && ready;

    // Strobe length counter; omitted entirely for single-clock strobes.
    generate
        if (WAIT_CLKS == 1) begin : g_no_cnt
            assign strobe_done = 1'b1;
        end else begin : g_cnt
            localparam int CNT_W = $clog2(WAIT_CLKS);
            localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CLKS - 1);
            logic [CNT_W-1:0] cnt_q;
            logic             entering;

            assign entering = (state_d != state_q) &&
                              ((state_d == ST_WR_STROBE) || (state_d == ST_RD_STROBE));

            // Load on strobe entry, count down while the strobe lasts.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (entering)
                    cnt_q <= CNT_LOAD;
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end

            assign strobe_done = (cnt_q == '0);
        end
    endgenerate

    // Read data is taken on the final clock of the read strobe.
    assign rd_sample = (state_q == ST_RD_STROBE) && strobe_done;

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept) state_d = req_write ? ST_WR_SETUP : ST_RD_STROBE;
            ST_WR_SETUP:   state_d = ST_WR_STROBE;
            ST_WR_STROBE:  if (strobe_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    state_d = ST_IDLE;
            ST_RD_STROBE:  if (strobe_done) state_d = ST_RD_RECOVER;
            ST_RD_RECOVER: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign state_nxt = state_d;

endmodule

// File: rtl/sram_pin_drive.sv
// Registered memory-side pins. Control levels come from the next sequencer
// state; address and write data load on the accept edge and hold until the
// next accept, so they stay put through the write strobe's rising edge.
// Assumes the sequencer never asks for both strobes in one state.
module sram_pin_drive
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_nxt,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    pin_intent_t nxt;

    assign nxt = intent_of(state_nxt);

    // Control pins: standby and all strobes off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce1_n <= 1'b1;
            sram_ce2   <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            dq_oe      <= 1'b0;
        end else begin
            sram_ce1_n <= ~nxt.chip_sel;
            sram_ce2   <= nxt.chip_sel;
            sram_we_n  <= ~nxt.wr_strobe;
            sram_oe_n  <= ~nxt.rd_strobe;
            dq_oe      <= nxt.bus_drive;
        end
    end

    // Address register: loads once per access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sram_addr <= '0;
        else if (accept)
            sram_addr <= req_addr;
    end

    // Write data register: loads only for writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dq_out <= '0;
        else if (accept && req_write)
            dq_out <= req_wdata;
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Read return path: samples the data bus when told and raises a one-clock
// valid pulse. Assumes the bus is settled at the sample clock.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sample,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    // Capture register; rdata holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= rd_sample;
            if (rd_sample)
                rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_port_ctrl.sv
// Top of the asynchronous SRAM port controller: sequencer, pin register
// stage and read capture. One access at a time through req/ready.
// Assumes WAIT_CLKS >= 1 and that dq_in is the resolved bus value.
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WAIT_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    logic       accept;
    logic       rd_sample;
    seq_state_e state_nxt;

    sram_seq_fsm #(
        .WAIT_CLKS (WAIT_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .ready     (ready),
        .accept    (accept),
        .rd_sample (rd_sample),
        .state_nxt (state_nxt)
    );

    sram_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_nxt  (state_nxt),
        .accept     (accept),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .sram_addr  (sram_addr),
        .sram_ce1_n (sram_ce1_n),
        .sram_ce2   (sram_ce2),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_sample   (rd_sample),
        .dq_in       (dq_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

endmodule

// File: rtl/sram_port_ctrl_chk.sv
// Protocol checker for sram_port_ctrl, attached by bind below.
// Assumes rst_n is held low for at least one clock at start.
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rdata_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    assert_standby_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !dq_oe));

    assert_write_strobe_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce1_n && sram_ce2 && dq_oe));

    assert_valid_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    assert_write_pins_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> ($stable(sram_addr) && $stable(dq_out)));

    assert_no_drive_under_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> sram_oe_n);

    assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |=> !dq_oe);

    assert_no_strobe_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    assert_accept_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    assert_reset_to_standby_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> (ready && sram_ce1_n && !sram_ce2 && !dq_oe));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ready       (ready),
    .rdata_valid (rdata_valid),
    .sram_addr   (sram_addr),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2    (sram_ce2),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe)
);

// File: tb/sim_sram_port_ctrl.sv
// Bench for sram_port_ctrl: behavioural SRAM model, directed corner cases
// and seeded random traffic, checked against a bench-side reference store.
module sim_sram_port_ctrl;

    localparam int WAIT_CLKS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic [15:0] sram_addr;
    logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sram_port_ctrl #(.WAIT_CLKS(WAIT_CLKS)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
        .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Power-up content of a never-written location.
    function automatic logic [7:0] init_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    // ---------------- memory model ----------------
    logic [7:0] model_mem [logic [15:0]];
    logic [7:0] model_q = '0;
    logic       model_drv;
    logic [15:0] wr_addr_at_fall;
    logic [7:0]  wr_data_at_fall;
    int mon_r1 = 0, mon_r4 = 0, mon_r6 = 0, mon_r7 = 0;
    bit prev_oe_low = 1'b0;

    assign model_drv = !sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n;
    assign dq_in = model_drv ? model_q : (dq_oe ? dq_out : 8'h00);

    always @(negedge clk)
        model_q <= model_mem.exists(sram_addr) ? model_mem[sram_addr] : init_val(sram_addr);

    always @(negedge sram_we_n) begin
        wr_addr_at_fall = sram_addr;
        wr_data_at_fall = dq_out;
    end

    always @(posedge sram_we_n) begin
        if (!sram_ce1_n && sram_ce2) begin
            if (sram_addr !== wr_addr_at_fall || dq_out !== wr_data_at_fall || !dq_oe)
                mon_r4++;
            model_mem[sram_addr] = dq_out;
        end
    end

    // Cycle monitors for standby, bus turnaround and strobe overlap.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ready && !(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !dq_oe)) mon_r1++;
            if (dq_oe && (!sram_oe_n || prev_oe_low || model_drv)) mon_r6++;
            if (!sram_we_n && !sram_oe_n) mon_r7++;
            prev_oe_low = !sram_oe_n;
        end else begin
            prev_oe_low = 1'b0;
        end
    end

    // ---------------- reference and checking ----------------
    logic [7:0] ref_mem [logic [15:0]];

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access through the handshake with phase-by-phase pin checks.
    task automatic do_op(input bit wr, input logic [15:0] a, input logic [7:0] d, input bit intrude);
        int  busy = -1;
        int  vld_at = -1;
        logic [7:0] got = '0;
        bit  phase_ok = 1'b1;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int n = 0; n < WAIT_CLKS + 6; n++) begin
            if (intrude && n == 1) begin
                req = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0101; req_wdata = ~d;
            end
            if (intrude && n == WAIT_CLKS) req = 1'b0;
            if (rdata_valid) begin
                if (vld_at < 0) begin vld_at = n; got = rdata; end
                else phase_ok = 1'b0;
            end
            if (ready) begin busy = n; break; end
            if (wr) begin
                if (sram_we_n !== ((n >= 1 && n <= WAIT_CLKS) ? 1'b0 : 1'b1)) phase_ok = 1'b0;
                if (sram_ce1_n !== 1'b0 || sram_ce2 !== 1'b1 || dq_oe !== 1'b1 || sram_oe_n !== 1'b1) phase_ok = 1'b0;
                if (sram_addr !== a || dq_out !== d) phase_ok = 1'b0;
            end else begin
                if (sram_oe_n !== ((n < WAIT_CLKS) ? 1'b0 : 1'b1)) phase_ok = 1'b0;
                if (sram_ce2 !== (n < WAIT_CLKS) || dq_oe !== 1'b0) phase_ok = 1'b0;
                if (n < WAIT_CLKS && sram_addr !== a) phase_ok = 1'b0;
            end
            @(negedge clk);
        end
        if (wr) begin
            check("R2 write pin phases", phase_ok, phase_ok, 1);
            check("R2 write busy length", busy == WAIT_CLKS + 2, busy, WAIT_CLKS + 2);
            ref_mem[a] = d;
        end else begin
            check("R3 read pin phases", phase_ok, phase_ok, 1);
            check("R3 rdata_valid timing", vld_at == WAIT_CLKS, vld_at, WAIT_CLKS);
            check("R5 read busy length", busy == WAIT_CLKS + 1, busy, WAIT_CLKS + 1);
            check("R9 read data", got === ref_rd(a), got, ref_rd(a));
        end
    endtask

    logic [15:0] pool [16];

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++)
            pool[i] = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 4099);

        repeat (3) @(negedge clk);
        // R1/R10: standby straight out of reset.
        check("R1 reset standby",
              ready && sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !dq_oe && !rdata_valid,
              {ready, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, dq_oe}, 6'b110110);
        rst_n = 1'b1;

        // Directed: both ends of the address range, unwritten location.
        do_op(1'b1, 16'h0000, 8'hA5, 1'b0);
        do_op(1'b1, 16'hFFFF, 8'h3C, 1'b0);
        do_op(1'b0, 16'hFFFF, 8'h00, 1'b0);
        do_op(1'b0, 16'h0000, 8'h00, 1'b0);
        do_op(1'b0, 16'h1234, 8'h00, 1'b0);
        // Read followed at once by write, then read back (R6 gap exercised).
        do_op(1'b0, 16'h00FF, 8'h00, 1'b0);
        do_op(1'b1, 16'h00FF, 8'h81, 1'b0);
        do_op(1'b0, 16'h00FF, 8'h00, 1'b0);

        // R8: requests while busy are ignored; the intruder's target keeps its value.
        do_op(1'b1, 16'h4242, 8'h11, 1'b1);
        do_op(1'b0, 16'h4242 ^ 16'h0101, 8'h00, 1'b0);
        check("R8 busy request ignored", ref_rd(16'h4343) === init_val(16'h4343),
              ref_rd(16'h4343), init_val(16'h4343));
        do_op(1'b0, 16'h4242, 8'h00, 1'b1);
        do_op(1'b0, 16'h4242 ^ 16'h0101, 8'h00, 1'b0);

        // R10: reset during the setup clock of a write.
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 16'h7777; req_wdata = 8'hEE;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset mid-access",
              ready && sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !dq_oe,
              {ready, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, dq_oe}, 6'b110110);
        rst_n = 1'b1;
        do_op(1'b1, 16'h0000, 8'h5A, 1'b0);
        do_op(1'b0, 16'h0000, 8'h00, 1'b0);

        // Seeded random traffic over the address pool.
        for (int k = 0; k < 300; k++) begin
            bit wr = 1'($urandom_range(0, 1));
            logic [15:0] a = pool[$urandom_range(0, 15)];
            logic [7:0] d = 8'($urandom());
            do_op(wr, a, d, 1'b0);
        end

        check("R1 standby monitor", mon_r1 == 0, mon_r1, 0);
        check("R4 write stability monitor", mon_r4 == 0, mon_r4, 0);
        check("R6 turnaround monitor", mon_r6 == 0, mon_r6, 0);
        check("R7 strobe overlap monitor", mon_r7 == 0, mon_r7, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule